// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the slave side of a two-wire serial control bus. It holds a small bank of byte-wide control registers. Those registers drive the per-output clock enable bits and the output amplitude selection of a clock fanout chip. The block answers only to one fixed 7-bit slave address. It supports single-byte writes and reads, and also counted block writes and block reads that walk upward through the register indices.

SCL and SDA are sampled with a system clock that runs much faster than SCL. Both lines pass through a synchronizer, and START and STOP are found as SDA edges while SCL is high. The slave only ever pulls SDA low, through the `sda_oe` enable. It never stretches the clock. A reset returns every register to its power-on value.

The command byte carries the access mode in its top bit and the starting register index in its low seven bits. In block mode, a write sends a byte count before the data. A block read returns the byte-count register before the data bytes.

Top module: `smb_ctrl_slave`

## Requirements
- R1: Only the address byte 0xD6 (7-bit address 0x6B) plus the R/W bit is acknowledged. For any other address, `sda_oe` stays low for the rest of the transfer and the registers do not change.
- R2: A write whose command byte has bit 7 = 1 is a byte write. The data byte goes to register index cmd[6:0]. Any further data bytes are acknowledged and discarded.
- R3: A read after a command byte with bit 7 = 1 is a byte read. The read sends register cmd[6:0] MSB first; the master NACKs it.
- R4: A write whose command byte has bit 7 = 0 is a block write. The first data byte is a count N. The next N bytes go to indices cmd[6:0], cmd[6:0]+1, and so on. Bytes past N are acknowledged and discarded.
- R5: A read after a command byte with bit 7 = 0 is a block read. It returns register 4 (the byte-count register) first, then registers cmd[6:0], cmd[6:0]+1, and so on. The read continues while the master ACKs and ends at the master NACK.
- R6: After reset, registers 0..5 hold 0x00, 0x17, 0xF8, 0x08, 0x06, 0xD8. `out_en[0]` is reg1 bit 4. `out_en[1..3]` are reg1 bits 2, 1, 0. `out_en[4..8]` are reg2 bits 7..3. A value of 1 means enabled.
- R7: `amp_sel` is reg5 bit 7, `amp_code` is reg5 bits 6:4, and `amp_mv` = 300 + 100 × `amp_code` (300 to 1000 mV).
- R8: Writes to indices above 5 are acknowledged and discarded. Reads of those indices return 0x00.
- R9: Reserved bits are stored as written and read back unchanged.
- R10: `sda_oe` and the register outputs change only while SCL is low. SDA is released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| out_en | output | 9 | Per-output clock enables |
| amp_sel | output | 1 | Custom amplitude select |
| amp_code | output | 3 | Amplitude code |
| amp_mv | output | 11 | Decoded amplitude in millivolts |

## Verification
Two functions can fall in the same cycle. One is the block-read path fetching the byte-count register as its leading byte. The other is a burst whose ascending range also covers index 4. Random block writes that rewrite register 4 are therefore followed by block reads that start at indices 2 to 4. The bench model predicts the count appearing both as the header and again in sequence. The other collision is a repeated START arriving while the slave sits in its data-receive state after a command byte. Every byte and block read provokes this, and it is judged by the returned data matching the model.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

   localparam int BYTE_W  = 8;
   localparam int CNT_IDX = 4;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_CMD, S_WR, S_ACK, S_TX, S_MACK
   } link_st_t;

   function automatic logic [7:0] reg_reset(int i);
      case (i)
         1:       return 8'h17;
         2:       return 8'hF8;
         3:       return 8'h08;
         4:       return 8'h06;
         5:       return 8'hD8;
         default: return 8'h00;
      endcase
   endfunction

   // register index feeding clock enable o
   function automatic int en_byte(int o);
      return (o < 4) ? 1 : 2;
   endfunction

   // bit position inside that register
   function automatic int en_bit(int o);
      if (o == 0)     return 4;
      else if (o < 4) return 3 - o;
      else            return 11 - o;
   endfunction

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("smbr_sync needs at least two stages");
      end
      for (genvar g = 0; g < LINES; g++) begin : g_line
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
         end
         assign dout[g] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smbr_regbank.sv
module smbr_regbank
   import smbr_pkg::*;
#(
   parameter int NREG = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [6:0]        waddr,
   input  logic [7:0]        wdata,
   input  logic [6:0]        raddr,
   output logic [7:0]        rdata,
   output logic [NREG*8-1:0] regs_flat
);
   logic [7:0] r [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          r[g] <= reg_reset(g);
            else if (we && int'(waddr) == g)     r[g] <= wdata;
         end
         assign regs_flat[g*8 +: 8] = r[g];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (int'(raddr) == i) rdata = r[i];
   end
endmodule

// File: rtl/smbr_link.sv
module smbr_link
   import smbr_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR7 = 7'h6B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic [7:0] rdata,
   output logic [6:0] raddr,
   output logic       we,
   output logic [6:0] waddr,
   output logic [7:0] wdata,
   output logic       sda_oe
);
   link_st_t   st, after_st;
   logic       scl_d, sda_d;
   logic [7:0] sh;
   logic [3:0] bitcnt;
   logic [6:0] idx;
   logic [7:0] remain;
   logic       blk, rd_first, wr_first, nack;

   wire scl_rise  = scl_s & ~scl_d;
   wire scl_fall  = ~scl_s & scl_d;
   wire start_det = scl_s & scl_d & sda_d & ~sda_s;
   wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
   wire byte_done = scl_fall && (bitcnt == 4'd8);

   logic load_tx;
   always_comb begin
      load_tx = 1'b0;
      if (!start_det && !stop_det && scl_fall) begin
         if (st == S_ACK && after_st == S_TX) load_tx = 1'b1;
         if (st == S_MACK && !nack)           load_tx = 1'b1;
      end
   end

   assign raddr = (blk && rd_first) ? 7'(CNT_IDX) : idx;
   assign waddr = idx;
   assign wdata = sh;
   assign we    = !start_det && !stop_det && (st == S_WR) && byte_done &&
                  !wr_first && (remain != 8'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  after_st <= S_IDLE;
         sh <= '0;      bitcnt <= '0;  idx <= '0;  remain <= '0;
         blk <= 1'b0;   rd_first <= 1'b0;  wr_first <= 1'b0;
         nack <= 1'b0;  sda_oe <= 1'b0;
      end else if (start_det) begin
         st <= S_ADDR;  bitcnt <= '0;  sda_oe <= 1'b0;
      end else if (stop_det) begin
         st <= S_IDLE;  sda_oe <= 1'b0;
      end else if (load_tx) begin
         sh <= rdata;  sda_oe <= ~rdata[7];  bitcnt <= '0;  st <= S_TX;
         if (blk && rd_first) rd_first <= 1'b0;
         else                 idx <= idx + 7'd1;
      end else begin
         case (st)
            S_ADDR, S_CMD, S_WR: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  sh     <= {sh[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  bitcnt <= '0;
                  if (st == S_ADDR) begin
                     if (sh[7:1] == SLAVE_ADDR7) begin
                        sda_oe   <= 1'b1;
                        st       <= S_ACK;
                        after_st <= sh[0] ? S_TX : S_CMD;
                     end else begin
                        st <= S_IDLE;
                     end
                  end else if (st == S_CMD) begin
                     blk      <= ~sh[7];
                     idx      <= sh[6:0];
                     wr_first <= ~sh[7];
                     rd_first <= ~sh[7];
                     remain   <= 8'd1;
                     sda_oe   <= 1'b1;
                     st       <= S_ACK;
                     after_st <= S_WR;
                  end else begin
                     if (wr_first) begin
                        remain   <= sh;
                        wr_first <= 1'b0;
                     end else if (remain != 8'd0) begin
                        remain <= remain - 8'd1;
                        idx    <= idx + 7'd1;
                     end
                     sda_oe   <= 1'b1;
                     st       <= S_ACK;
                     after_st <= S_WR;
                  end
               end
            end
            S_ACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               bitcnt <= '0;
               st     <= after_st;
            end
            S_TX: begin
               if (scl_rise) bitcnt <= bitcnt + 4'd1;
               else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     st     <= S_MACK;
                  end else begin
                     sh     <= {sh[6:0], 1'b0};
                     sda_oe <= ~sh[6];
                  end
               end
            end
            S_MACK: begin
               if (scl_rise)      nack <= sda_s;
               else if (scl_fall) st   <= S_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/smb_ctrl_slave.sv
module smb_ctrl_slave
   import smbr_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR7 = 7'h6B,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_REGS    = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        sda_oe,
   output logic [8:0]  out_en,
   output logic        amp_sel,
   output logic [2:0]  amp_code,
   output logic [10:0] amp_mv
);
   localparam int NUM_OUT = 9;
   localparam int AMP_IDX = 5;

   generate
      if (NUM_REGS <= AMP_IDX) begin : g_bad
         $error("register bank too small for the control map");
      end
   endgenerate

   logic [1:0]            sync_q;
   logic                  we;
   logic [6:0]            waddr, raddr;
   logic [7:0]            wdata, rdata;
   logic [NUM_REGS*8-1:0] regs_flat;

   smbr_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({scl_in, sda_in}), .dout(sync_q));

   smbr_link #(.SLAVE_ADDR7(SLAVE_ADDR7)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_s(sync_q[1]), .sda_s(sync_q[0]),
      .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr),
      .wdata(wdata), .sda_oe(sda_oe));

   smbr_regbank #(.NREG(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .regs_flat(regs_flat));

   generate
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_en
         assign out_en[o] = regs_flat[en_byte(o)*8 + en_bit(o)];
      end
   endgenerate

   assign amp_sel  = regs_flat[AMP_IDX*8 + 7];
   assign amp_code = regs_flat[AMP_IDX*8 + 4 +: 3];
   assign amp_mv   = 11'd300 + 11'd100 * {8'd0, amp_code};
endmodule

// File: rtl/smbr_checker.sv
module smbr_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_in,
   input logic        sda_oe,
   input logic [8:0]  out_en,
   input logic        amp_sel,
   input logic [2:0]  amp_code,
   input logic [10:0] amp_mv
);
   logic was_rst;
   always_ff @(posedge clk) was_rst <= !rst_n;

   a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_in);

   a_r10_regs_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      ({out_en, amp_sel, amp_code} != $past({out_en, amp_sel, amp_code})) |-> !scl_in);

   a_r6_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      was_rst |-> (out_en == 9'h1FF && amp_sel && amp_code == 3'b101 && !sda_oe));

   a_r7_amp_range: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_mv >= 11'd300) && (amp_mv <= 11'd1000));
endmodule

bind smb_ctrl_slave smbr_checker u_chk (.*);

// File: tb/smb_ctrl_slave_test.sv
module smb_ctrl_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;
   localparam int WD_LIMIT   = 190000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, amp_sel;
   logic [8:0] out_en;
   logic [2:0] amp_code;
   logic [10:0] amp_mv;
   wire  sda_bus = sda_m & ~sda_oe;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   logic [7:0] m [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_ctrl_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_oe(sda_oe), .out_en(out_en), .amp_sel(amp_sel), .amp_code(amp_code),
      .amp_mv(amp_mv));

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic w(int n); repeat (n) @(negedge clk); endtask

   function automatic logic [7:0] exp_rd(int i);
      return (i < 6) ? m[i] : 8'h00;
   endfunction

   function automatic logic [8:0] exp_en();
      return {m[2][3], m[2][4], m[2][5], m[2][6], m[2][7],
              m[1][0], m[1][1], m[1][2], m[1][4]};
   endfunction

   task automatic model_reset();
      m[0] = 8'h00; m[1] = 8'h17; m[2] = 8'hF8; m[3] = 8'h08;
      m[4] = 8'h06; m[5] = 8'hD8; m[6] = 8'h00; m[7] = 8'h00;
   endtask

   task automatic chk_outs(string req);
      chk(req, {7'd0, out_en}, {7'd0, exp_en()});
      chk(req, {12'd0, amp_sel, amp_code}, {12'd0, m[5][7:4]});
      chk(req, {5'd0, amp_mv}, 16'(300 + 100 * int'(m[5][6:4])));
   endtask

   task automatic bus_start();
      sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0;
   endtask

   task automatic bus_stop();
      sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
      chk("R10 released after stop", {15'd0, sda_oe}, 16'd0);
   endtask

   task automatic send(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; w(H); scl_m = 1; w(H); scl_m = 0;
      end
      sda_m = 1; w(H); scl_m = 1; w(H/2); ack = sda_bus; w(H/2); scl_m = 0;
   endtask

   task automatic recv(logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1; w(H); scl_m = 1; w(H/2); b[i] = sda_bus; w(H/2); scl_m = 0;
      end
      sda_m = mack; w(H); scl_m = 1; w(H); scl_m = 0;
   endtask

   task automatic byte_write(int idx, logic [7:0] d, string req);
      logic a0, a1, a2;
      bus_start(); send(8'hD6, a0); send(8'h80 | 8'(idx), a1); send(d, a2); bus_stop();
      chk({req, " acks"}, {13'd0, a0, a1, a2}, 16'd0);
      if (idx < 6) m[idx] = d;
   endtask

   task automatic byte_read(int idx, string req);
      logic a0, a1, a2; logic [7:0] d;
      bus_start(); send(8'hD6, a0); send(8'h80 | 8'(idx), a1);
      bus_start(); send(8'hD7, a2); recv(1'b1, d); bus_stop();
      chk({req, " acks"}, {13'd0, a0, a1, a2}, 16'd0);
      chk({req, " data"}, {8'd0, d}, {8'd0, exp_rd(idx)});
   endtask

   task automatic block_write(int idx, int cnt, int n, string req);
      logic a; logic [7:0] d; logic [15:0] acks;
      acks = 0;
      bus_start(); send(8'hD6, a); acks[0] = a;
      send(8'(idx), a); acks[1] = a; send(8'(cnt), a); acks[2] = a;
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         send(d, a); acks[3+k] = a;
         if (k < cnt && idx + k < 6) m[idx+k] = d;
      end
      bus_stop();
      chk({req, " acks"}, acks, 16'd0);
   endtask

   task automatic block_read(int idx, int n, string req);
      logic a0, a1, a2; logic [7:0] d;
      bus_start(); send(8'hD6, a0); send(8'(idx), a1);
      bus_start(); send(8'hD7, a2);
      chk({req, " acks"}, {13'd0, a0, a1, a2}, 16'd0);
      recv(1'b0, d);
      chk({req, " count first"}, {8'd0, d}, {8'd0, m[4]});
      for (int k = 0; k < n; k++) begin
         recv(k == n - 1, d);
         chk({req, " data"}, {8'd0, d}, {8'd0, exp_rd(idx + k)});
      end
      bus_stop();
   endtask

   initial begin
      logic a0, a1, a2;
      void'($urandom(32'd2024));
      model_reset();
      w(5); rst_n = 1; w(3);
      chk("R6 reset sda", {15'd0, sda_oe}, 16'd0);
      chk_outs("R6 reset outputs");

      // R2 / R6 mapping, R3 readback
      byte_write(1, 8'h00, "R2 byte write");
      chk_outs("R2 enables cleared");
      byte_read(1, "R3 byte read");
      byte_write(2, 8'h50, "R2 byte write reg2");
      chk_outs("R6 enable map reg2");
      // R9 reserved bits
      byte_write(0, 8'hA5, "R9 reserved write");
      byte_read(0, "R9 reserved readback");
      // R7 amplitude
      byte_write(5, 8'h3B, "R7 amp write");
      chk_outs("R7 amp code 011");
      byte_write(5, 8'hC0, "R7 amp write");
      chk_outs("R7 amp code 100");
      // R1 wrong address
      bus_start(); send(8'hD4, a0); send(8'h81, a1); send(8'h00, a2); bus_stop();
      chk("R1 foreign address nack", {13'd0, a0, a1, a2}, 16'h7);
      chk_outs("R1 state unchanged");
      byte_read(1, "R1 register unchanged");
      // R8 out of range
      byte_write(6, 8'h77, "R8 high index write");
      byte_read(6, "R8 high index read");
      chk_outs("R8 no side effect");
      // R2 extra byte discarded
      bus_start(); send(8'hD6, a0); send(8'h83, a1); send(8'h11, a2); m[3] = 8'h11;
      send(8'h22, a0); bus_stop();
      chk("R2 extra byte acked", {15'd0, a0}, 16'd0);
      byte_read(4, "R2 extra byte discarded");
      // R4 block write with excess byte, R5 block read
      block_write(1, 2, 3, "R4 block write");
      chk_outs("R4 block write outputs");
      block_read(1, 3, "R4 excess discarded");
      block_read(3, 3, "R5 block read");

      for (int it = 0; it < 36; it++) begin
         int kind, idx;
         kind = int'($urandom % 4);
         idx  = int'($urandom % 8);
         case (kind)
            0: byte_write(idx, 8'($urandom), "R2 random");
            1: byte_read(idx, "R3 random");
            2: block_write(idx, 1 + int'($urandom % 3), 1 + int'($urandom % 4), "R4 random");
            default: block_read(idx, 1 + int'($urandom % 3), "R5 random");
         endcase
         chk_outs("R6 random outputs");
      end

      rst_n = 0; w(3); rst_n = 1; w(2);
      model_reset();
      chk_outs("R6 reset mid-run");
      byte_read(5, "R6 reg5 after reset");
      finish_run();
   end
endmodule